// File: doc/BRIEF.md
# Byte-to-Word Packer with Left-over Byte Recovery

This block sits between an 8-bit SCSI data port and a 16-bit system bus. In the receive direction it collects bytes from a valid/ready stream into two 16-bit packing registers (a high one and a low one). It issues word writes only when a group of four byte positions has been filled. In the send direction it takes 16-bit words and hands them out as bytes, upper byte first.

A transfer is opened with a start pulse that captures the direction, the byte-packing control bit and the transfer length. The byte-packing control bit is set when the buffer starts on a half-word boundary (address bit 1 set). The transfer is closed with a stop pulse. When a receive transfer stops early, the packing registers still hold up to three bytes that were never written. A left-over count and the two packing registers stay visible so that software can copy those bytes by hand. A residual output gives the untransferred byte count. In the send direction it carries the one-byte overshoot that a disconnect causes.

Top module: `pk_byte_packer`

## Requirements
- R1: After reset, byte_in_ready, word_in_ready, byte_out_valid and word_wr_en are low, and lob_count, pack_hi, pack_lo and resid are zero.
- R2: In receive, byte positions 0..3 map to pack_hi[15:8], pack_hi[7:0], pack_lo[15:8], pack_lo[7:0]. When position 3 is filled after a full group, the block writes pack_hi in the next cycle and pack_lo in the cycle after. byte_in_ready is low during both write cycles.
- R3: In receive, no word write happens until position 3 is filled. The bytes received so far stay in the packing registers.
- R4: In receive, lob_count gives the number of bytes held (0 to 3). One byte sits in pack_hi[15:8]. Two bytes fill pack_hi. Three bytes fill pack_hi and pack_lo[15:8].
- R5: With half_ofs set at start, the first byte goes to position 2. That first group issues a single word write of pack_lo. A lone left-over byte of that group sits in pack_lo[15:8], with lob_count 1 and pack_hi zero.
- R6: In the send direction, lob_count is always zero.
- R7: In send, each accepted word is emitted on byte_out_data as bits [15:8] first, then bits [7:0].
- R8: resid equals the transfer length minus the bytes moved. In send only, when that value lies strictly between zero and the length, resid is one less. Right after start, resid equals xfer_len.
- R9: fifo_clr zeroes pack_hi, pack_lo, lob_count and resid, and closes any transfer.
- R10: After xfer_stop, byte_in_ready and word_in_ready stay low, and the packing registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous clear of packing state and transfer |
| xfer_start | input | 1 | Opens a transfer, capturing dir_send, half_ofs and xfer_len |
| xfer_stop | input | 1 | Closes the transfer |
| dir_send | input | 1 | 1 = send (words to bytes), 0 = receive |
| half_ofs | input | 1 | Byte-packing control: buffer starts on address bit 1 |
| xfer_len | input | LEN_W | Transfer length in bytes |
| byte_in_valid | input | 1 | Receive byte valid |
| byte_in_ready | output | 1 | Receive byte ready |
| byte_in_data | input | BYTE_W | Receive byte |
| word_wr_en | output | 1 | Word write strobe to the system bus |
| word_wr_data | output | 2*BYTE_W | Packed word |
| word_in_valid | input | 1 | Send word valid |
| word_in_ready | output | 1 | Send word ready |
| word_in_data | input | 2*BYTE_W | Send word |
| byte_out_valid | output | 1 | Send byte valid |
| byte_out_ready | input | 1 | Send byte ready |
| byte_out_data | output | BYTE_W | Send byte |
| pack_hi | output | 2*BYTE_W | High packing register |
| pack_lo | output | 2*BYTE_W | Low packing register |
| lob_count | output | 2 | Left-over byte count |
| resid | output | LEN_W | Reported residual byte count |

## Verification
The receive path is driven with an aligned run of two full groups, where the exact order of the word writes separates the high and low registers. It is then stopped after one, two and three bytes, which shows whether each position lands in the right half of the right register. A half-offset run, both completed and stopped after one byte, separates the position-2 start from an aligned start. The send path is stopped with no bytes, some bytes and all bytes moved, which tells the overshoot correction apart from the plain residual at both of its edges.

// File: rtl/pk_pkg.sv
package pk_pkg;
    localparam int unsigned GROUP_LANES = 4;

    typedef enum logic [1:0] {
        ST_FILL    = 2'd0,
        ST_EMIT_HI = 2'd1,
        ST_EMIT_LO = 2'd2
    } pk_state_e;
endpackage

// File: rtl/pk_lane_steer.sv
module pk_lane_steer #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic [1:0]          pos,
    input  logic                wr,
    input  logic [BYTE_W-1:0]   din,
    input  logic [2*BYTE_W-1:0] hi_in,
    input  logic [2*BYTE_W-1:0] lo_in,
    output logic [2*BYTE_W-1:0] hi_out,
    output logic [2*BYTE_W-1:0] lo_out
);
    localparam int unsigned LANES = pk_pkg::GROUP_LANES;
    localparam int unsigned GRP_W = LANES * BYTE_W;

    logic [GRP_W-1:0] grp_cur;
    logic [GRP_W-1:0] grp_nxt;

    assign grp_cur = {hi_in, lo_in};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int unsigned TOP = GRP_W - 1 - l * BYTE_W;
        assign grp_nxt[TOP -: BYTE_W] =
            (wr && (pos == l[1:0])) ? din : grp_cur[TOP -: BYTE_W];
    end

    assign hi_out = grp_nxt[GRP_W-1 -: 2*BYTE_W];
    assign lo_out = grp_nxt[2*BYTE_W-1:0];
endmodule

// File: rtl/pk_resid_calc.sv
module pk_resid_calc #(
    parameter int unsigned LEN_W = 16
) (
    input  logic             send_dir,
    input  logic [LEN_W-1:0] len,
    input  logic [LEN_W-1:0] moved,
    output logic [LEN_W-1:0] resid
);
    logic [LEN_W-1:0] remain;
    logic             partial;

    always_comb begin
        remain  = len - moved;
        partial = send_dir && (remain != '0) && (remain < len);
        resid   = partial ? remain - 1'b1 : remain;
    end
endmodule

// File: rtl/pk_byte_packer.sv
module pk_byte_packer #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned LEN_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fifo_clr,
    input  logic                xfer_start,
    input  logic                xfer_stop,
    input  logic                dir_send,
    input  logic                half_ofs,
    input  logic [LEN_W-1:0]    xfer_len,
    input  logic                byte_in_valid,
    output logic                byte_in_ready,
    input  logic [BYTE_W-1:0]   byte_in_data,
    output logic                word_wr_en,
    output logic [2*BYTE_W-1:0] word_wr_data,
    input  logic                word_in_valid,
    output logic                word_in_ready,
    input  logic [2*BYTE_W-1:0] word_in_data,
    output logic                byte_out_valid,
    input  logic                byte_out_ready,
    output logic [BYTE_W-1:0]   byte_out_data,
    output logic [2*BYTE_W-1:0] pack_hi,
    output logic [2*BYTE_W-1:0] pack_lo,
    output logic [1:0]          lob_count,
    output logic [LEN_W-1:0]    resid
);
    import pk_pkg::*;

    localparam int unsigned WORD_W = 2 * BYTE_W;

    typedef struct packed {
        pk_state_e         st;
        logic              active;
        logic              send;
        logic [1:0]        pos;
        logic [2:0]        held;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  moved;
    } pk_regs_t;

    pk_regs_t q, d;

    logic              rx_take;
    logic              tx_word_take;
    logic              tx_byte_take;
    logic [WORD_W-1:0] hi_steer;
    logic [WORD_W-1:0] lo_steer;

    pk_lane_steer #(.BYTE_W(BYTE_W)) u_steer (
        .pos    (q.pos),
        .wr     (rx_take),
        .din    (byte_in_data),
        .hi_in  (q.hi),
        .lo_in  (q.lo),
        .hi_out (hi_steer),
        .lo_out (lo_steer)
    );

    pk_resid_calc #(.LEN_W(LEN_W)) u_resid (
        .send_dir (q.send),
        .len      (q.len),
        .moved    (q.moved),
        .resid    (resid)
    );

    always_comb begin
        byte_in_ready  = q.active && !q.send && (q.st == ST_FILL);
        word_in_ready  = q.active && q.send && (q.held == 3'd0);
        byte_out_valid = q.active && q.send && (q.held != 3'd0);
        byte_out_data  = (q.held == 3'd2) ? q.hi[WORD_W-1 -: BYTE_W]
                                          : q.hi[BYTE_W-1:0];
        word_wr_en     = (q.st != ST_FILL);
        word_wr_data   = (q.st == ST_EMIT_HI) ? q.hi : q.lo;
        pack_hi        = q.hi;
        pack_lo        = q.lo;
        lob_count      = (!q.send && (q.st == ST_FILL)) ? q.held[1:0] : 2'd0;

        rx_take      = byte_in_valid && byte_in_ready;
        tx_word_take = word_in_valid && word_in_ready;
        tx_byte_take = byte_out_valid && byte_out_ready;
    end

    always_comb begin
        d = q;
        if (fifo_clr) begin
            d.st     = ST_FILL;
            d.active = 1'b0;
            d.pos    = 2'd0;
            d.held   = 3'd0;
            d.hi     = '0;
            d.lo     = '0;
            d.len    = '0;
            d.moved  = '0;
        end else if (xfer_start) begin
            d.st     = ST_FILL;
            d.active = 1'b1;
            d.send   = dir_send;
            d.pos    = half_ofs ? 2'd2 : 2'd0;
            d.held   = 3'd0;
            d.hi     = '0;
            d.lo     = '0;
            d.len    = xfer_len;
            d.moved  = '0;
        end else begin
            if (xfer_stop) begin
                d.active = 1'b0;
            end
            unique case (q.st)
                ST_FILL: begin
                    if (rx_take) begin
                        d.hi    = hi_steer;
                        d.lo    = lo_steer;
                        d.held  = q.held + 3'd1;
                        d.moved = q.moved + 1'b1;
                        d.pos   = q.pos + 2'd1;
                        if (q.pos == 2'd3) begin
                            d.st = (q.held == 3'd3) ? ST_EMIT_HI : ST_EMIT_LO;
                        end
                    end
                    if (tx_word_take) begin
                        d.hi   = word_in_data;
                        d.held = 3'd2;
                    end
                    if (tx_byte_take) begin
                        d.held  = q.held - 3'd1;
                        d.moved = q.moved + 1'b1;
                    end
                end
                ST_EMIT_HI: begin
                    d.st = ST_EMIT_LO;
                end
                ST_EMIT_LO: begin
                    d.st   = ST_FILL;
                    d.hi   = '0;
                    d.lo   = '0;
                    d.held = 3'd0;
                end
                default: begin
                    d.st = ST_FILL;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_FILL, active: 1'b0, send: 1'b0, pos: 2'd0,
                   held: 3'd0, hi: '0, lo: '0, len: '0, moved: '0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/pk_byte_packer_chk.sv
module pk_byte_packer_chk #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned LEN_W  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fifo_clr,
    input logic                xfer_start,
    input logic                xfer_stop,
    input logic [LEN_W-1:0]    xfer_len,
    input logic                byte_in_ready,
    input logic                word_in_ready,
    input logic                byte_out_valid,
    input logic                word_wr_en,
    input logic [1:0]          lob_count,
    input logic [2*BYTE_W-1:0] pack_hi,
    input logic [2*BYTE_W-1:0] pack_lo,
    input logic [LEN_W-1:0]    resid
);
    // R2: no byte is taken while a word write is on the bus
    assert_no_take_in_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_wr_en |-> !byte_in_ready);

    // R6: send direction never reports left-over bytes
    assert_no_lob_in_send_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_out_valid |-> (lob_count == 2'd0));

    // R8: residual equals the loaded length right after start
    assert_resid_loaded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !fifo_clr) |=> (resid == $past(xfer_len)));

    // R9: clear empties the packing state
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (lob_count == 2'd0 && pack_hi == '0 && pack_lo == '0 && resid == '0));

    // R10: stop closes both input sides
    assert_stop_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stop && !xfer_start && !fifo_clr) |=> (!byte_in_ready && !word_in_ready));
endmodule

bind pk_byte_packer pk_byte_packer_chk #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/test_pk_byte_packer.sv
module test_pk_byte_packer;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LEN_W  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_clr = 1'b0;
    logic        xfer_start = 1'b0;
    logic        xfer_stop = 1'b0;
    logic        dir_send = 1'b0;
    logic        half_ofs = 1'b0;
    logic [15:0] xfer_len = '0;
    logic        byte_in_valid = 1'b0;
    logic        byte_in_ready;
    logic [7:0]  byte_in_data = '0;
    logic        word_wr_en;
    logic [15:0] word_wr_data;
    logic        word_in_valid = 1'b0;
    logic        word_in_ready;
    logic [15:0] word_in_data = '0;
    logic        byte_out_valid;
    logic        byte_out_ready = 1'b0;
    logic [7:0]  byte_out_data;
    logic [15:0] pack_hi, pack_lo;
    logic [1:0]  lob_count;
    logic [15:0] resid;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [15:0] exp_words[$];

    always #5 clk = ~clk;

    pk_byte_packer #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) i_pk_byte_packer (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    // monitor: compare every word write against the scoreboard
    always @(negedge clk) begin
        if (rst_n && word_wr_en) begin
            if (exp_words.size() == 0) begin
                chk(1'b0, "R3 unexpected word write", {16'h0, word_wr_data}, 32'h0);
            end else begin
                logic [15:0] e;
                e = exp_words.pop_front();
                eq("R2 word order", {16'h0, word_wr_data}, {16'h0, e});
            end
        end
    end

    task automatic start(input bit snd, input bit ofs, input logic [15:0] len);
        @(negedge clk);
        xfer_start = 1'b1; dir_send = snd; half_ofs = ofs; xfer_len = len;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic stop();
        @(negedge clk);
        xfer_stop = 1'b1;
        @(negedge clk);
        xfer_stop = 1'b0;
        #1;
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        byte_in_valid = 1'b1; byte_in_data = b;
        #1;
        while (!byte_in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 byte_in_valid = 1'b0;
    endtask

    task automatic put_word(input logic [15:0] w);
        @(negedge clk);
        word_in_valid = 1'b1; word_in_data = w;
        #1;
        while (!word_in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 word_in_valid = 1'b0;
    endtask

    task automatic take_byte(input logic [7:0] e);
        @(negedge clk);
        #1;
        while (!byte_out_valid) begin
            @(negedge clk);
            #1;
        end
        eq("R7 send byte order", {24'h0, byte_out_data}, {24'h0, e});
        eq("R6 lob zero in send", {30'h0, lob_count}, 32'h0);
        byte_out_ready = 1'b1;
        @(posedge clk);
        #1 byte_out_ready = 1'b0;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
        eq("R2 all words written", exp_words.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        eq("R1 byte_in_ready", {31'h0, byte_in_ready}, 0);
        eq("R1 word_wr_en", {31'h0, word_wr_en}, 0);
        eq("R1 word_in_ready", {31'h0, word_in_ready}, 0);
        eq("R1 byte_out_valid", {31'h0, byte_out_valid}, 0);
        eq("R1 lob_count", {30'h0, lob_count}, 0);
        eq("R1 pack regs", {pack_hi, pack_lo}, 0);
        eq("R1 resid", {16'h0, resid}, 0);
        rst_n = 1'b1;

        // R2 aligned receive, two full groups
        start(1'b0, 1'b0, 16'd8);
        eq("R8 resid at start", {16'h0, resid}, 8);
        exp_words.push_back(16'h1112); exp_words.push_back(16'h1314);
        exp_words.push_back(16'h1516); exp_words.push_back(16'h1718);
        put_byte(8'h11); put_byte(8'h12); put_byte(8'h13);
        #1 eq("R3 no write before group full", exp_words.size(), 4);
        put_byte(8'h14);
        for (int i = 5; i <= 8; i++) put_byte(8'h10 + 8'(i));
        drain();
        eq("R8 rx resid done", {16'h0, resid}, 0);
        stop();

        // R4 one left-over byte
        start(1'b0, 1'b0, 16'd16);
        put_byte(8'hA1);
        stop();
        eq("R4 lob one", {30'h0, lob_count}, 1);
        eq("R4 one byte hi", {16'h0, pack_hi}, 32'hA100);
        eq("R4 one byte lo", {16'h0, pack_lo}, 0);
        eq("R8 rx resid partial", {16'h0, resid}, 15);
        eq("R10 ready low after stop", {31'h0, byte_in_ready}, 0);

        // R4 two left-over bytes
        start(1'b0, 1'b0, 16'd16);
        put_byte(8'hA1); put_byte(8'hA2);
        stop();
        eq("R4 lob two", {30'h0, lob_count}, 2);
        eq("R4 two bytes hi", {16'h0, pack_hi}, 32'hA1A2);

        // R4 three left-over after a full group
        start(1'b0, 1'b0, 16'd16);
        exp_words.push_back(16'h2122); exp_words.push_back(16'h2324);
        put_byte(8'h21); put_byte(8'h22); put_byte(8'h23); put_byte(8'h24);
        put_byte(8'h31); put_byte(8'h32); put_byte(8'h33);
        stop();
        eq("R2 group written", exp_words.size(), 0);
        eq("R4 lob three", {30'h0, lob_count}, 3);
        eq("R4 three hi", {16'h0, pack_hi}, 32'h3132);
        eq("R4 three lo", {16'h0, pack_lo}, 32'h3300);
        eq("R8 resid after 7", {16'h0, resid}, 9);
        repeat (2) @(negedge clk);
        eq("R10 regs kept after stop", {pack_hi, pack_lo}, 32'h31323300);

        // R9 clear
        @(negedge clk); fifo_clr = 1'b1;
        @(negedge clk); fifo_clr = 1'b0; #1;
        eq("R9 lob cleared", {30'h0, lob_count}, 0);
        eq("R9 regs cleared", {pack_hi, pack_lo}, 0);
        eq("R9 resid cleared", {16'h0, resid}, 0);

        // R5 half-offset, complete groups then one left over
        start(1'b0, 1'b1, 16'd32);
        exp_words.push_back(16'hB1B2);
        put_byte(8'hB1);
        #1 eq("R5 first byte in lo", {16'h0, pack_lo}, 32'hB100);
        put_byte(8'hB2);
        exp_words.push_back(16'hC1C2); exp_words.push_back(16'hC3C4);
        put_byte(8'hC1); put_byte(8'hC2); put_byte(8'hC3); put_byte(8'hC4);
        put_byte(8'hD1);
        stop();
        eq("R5 words done", exp_words.size(), 0);
        eq("R5 lob after realign", {30'h0, lob_count}, 1);
        eq("R5 realigned hi", {16'h0, pack_hi}, 32'hD100);

        // R5 half-offset, single byte
        start(1'b0, 1'b1, 16'd32);
        put_byte(8'hE1);
        stop();
        eq("R5 lob one", {30'h0, lob_count}, 1);
        eq("R5 single in lo", {16'h0, pack_lo}, 32'hE100);
        eq("R5 hi empty", {16'h0, pack_hi}, 0);

        // R7/R8 send, partial transfer
        start(1'b1, 1'b0, 16'd8);
        put_word(16'hA1B2);
        take_byte(8'hA1); take_byte(8'hB2);
        put_word(16'hC3D4);
        take_byte(8'hC3);
        stop();
        eq("R8 send overshoot", {16'h0, resid}, 4);
        eq("R6 lob send stop", {30'h0, lob_count}, 0);
        eq("R10 word ready low", {31'h0, word_in_ready}, 0);

        // R8 send, nothing moved
        start(1'b1, 1'b0, 16'd6);
        stop();
        eq("R8 send none moved", {16'h0, resid}, 6);

        // R8 send, everything moved
        start(1'b1, 1'b0, 16'd4);
        put_word(16'h1122);
        take_byte(8'h11); take_byte(8'h22);
        put_word(16'h3344);
        take_byte(8'h33); take_byte(8'h44);
        stop();
        eq("R8 send all moved", {16'h0, resid}, 0);

        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                chk(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule